// File: doc/BRIEF.md
# Configuration Image Byte Descrambler

This block strips a byte-wise keystream from a scrambled configuration image. The result then goes to a decompressor. Bytes arrive on a valid/ready input and leave on a valid/ready output. There is one output byte for each accepted input byte, in the same order.

For every accepted byte the block advances a 32-bit key and XORs the byte with the low eight bits of the advanced key. The key is advanced before it is used, so even the first byte after the seed sees a stepped key.

One step of the key works as follows, all in 32-bit wraparound arithmetic:

1. Add a fixed offset to the key.
2. Reduce that sum modulo 177.
3. Add the remainder to the key multiplied by a second constant.

The modulo reduction is done as a serial restoring remainder. It handles a configurable number of dividend bits per cycle, so only one byte is in flight at a time. A restart pulse reloads the seed and discards any byte that has not yet been handed off.

Top module: `cfg_descrambler`

## Requirements
- R1: After reset, `in_ready_o` is 1 and `out_valid_o` is 0, and the key holds the seed 0x3F6DF2AB.
- R2: The first byte accepted after reset is output as `in ^ K1[7:0]`. Here K1 = ((0x3F6DF2AB + 0x0A853753) mod 2^32) mod 177 + 0x3F6DF2AB × 0x08034052, taken modulo 2^32.
- R3: Each later byte is XORed with the low 8 bits of the key obtained by applying the same step once more to the previous key. The key changes exactly once per accepted byte.
- R4: `in_ready_o` is 0 from the edge that accepts a byte until the edge at which its result is taken on the output.
- R5: `out_valid_o` rises right after the (32/BITS_PER_CYCLE + 1)-th rising edge that follows the accepting edge.
- R6: While `out_valid_o` is 1 and `out_ready_i` is 0, `out_valid_o` stays 1 and `out_data_o` stays unchanged.
- R7: A `restart_i` pulse reloads the seed and returns the block to idle. A byte being computed or held on the output is dropped and never appears. The next accepted byte is treated as in R2.
- R8: When `restart_i` and `in_valid_i` are high in the same cycle, the byte is not accepted and `in_ready_o` remains 1 on the next cycle.
- R9: The number of output handshakes equals the number of accepted bytes minus those dropped by restart, and results appear in acceptance order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| restart_i | input | 1 | Synchronous pulse: reseed and drop any byte in flight |
| in_valid_i | input | 1 | Input byte valid |
| in_ready_o | output | 1 | Block can accept a byte |
| in_data_i | input | 8 | Scrambled input byte |
| out_valid_o | output | 1 | Descrambled byte valid |
| out_ready_i | input | 1 | Consumer takes the byte |
| out_data_o | output | 8 | Descrambled output byte |

## Verification
The hardest situation to reach is a restart that lands while a byte is in flight. That covers both a restart partway through the serial remainder and a restart while a finished result is parked behind a stalled consumer. In both cases the dropped byte must not appear and the key must begin again from the seed.

Directed sequences hold `out_ready_i` low to park a result, or wait a few cycles after acceptance, before pulsing `restart_i`. A third sequence raises `restart_i` together with `in_valid_i` while idle. Random traffic with sparse restarts and random back-pressure then mixes these cases with long chains of keystream steps.

// File: rtl/cfg_descr_pkg.sv
package cfg_descr_pkg;

    localparam int          KEY_BITS   = 32;
    localparam logic [31:0] KEY_SEED   = 32'h3F6D_F2AB;
    localparam logic [31:0] KEY_OFFSET = 32'h0A85_3753;
    localparam logic [31:0] KEY_FACTOR = 32'h0803_4052;
    localparam int          KEY_MOD    = 177;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_CALC = 2'd1,
        PH_HOLD = 2'd2
    } phase_e;

endpackage

// File: rtl/cfg_descr_rem.sv
// Serial restoring remainder: dividend mod MODULUS, BITS_PER_CYCLE bits per clock.
module cfg_descr_rem #(
    parameter int KEY_W          = 32,
    parameter int MODULUS        = 177,
    parameter int BITS_PER_CYCLE = 2,
    localparam int STEPS = KEY_W / BITS_PER_CYCLE,
    localparam int CNT_W = $clog2(STEPS + 1),
    localparam int RES_W = $clog2(MODULUS),
    localparam int REM_W = RES_W + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             abort_i,
    input  logic             start_i,
    input  logic [KEY_W-1:0] dividend_i,
    output logic             done_o,
    output logic [RES_W-1:0] rem_o
);

    typedef struct packed {
        logic [RES_W-1:0] rem;
        logic [KEY_W-1:0] shreg;
        logic [CNT_W-1:0] cnt;
    } rem_st_t;

    rem_st_t st_q, st_d;

    always_comb begin
        logic [REM_W-1:0] trial;
        trial = '0;
        st_d  = st_q;
        if (abort_i) begin
            st_d.cnt = '0;
        end else if (start_i) begin
            st_d.rem   = '0;
            st_d.shreg = dividend_i;
            st_d.cnt   = CNT_W'(STEPS);
        end else if (st_q.cnt != '0) begin
            for (int i = 0; i < BITS_PER_CYCLE; i++) begin
                trial = {st_d.rem, st_d.shreg[KEY_W-1]};
                if (trial >= REM_W'(MODULUS)) begin
                    trial = trial - REM_W'(MODULUS);
                end
                st_d.rem   = trial[RES_W-1:0];
                st_d.shreg = {st_d.shreg[KEY_W-2:0], 1'b0};
            end
            st_d.cnt = st_q.cnt - CNT_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign done_o = (st_q.cnt == '0);
    assign rem_o  = st_q.rem;

    AST_REM_BELOW_MOD: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.rem < RES_W'(MODULUS)); // R2

    AST_CNT_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !abort_i) |=> (st_q.cnt == CNT_W'(STEPS))); // R5

    AST_CNT_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.cnt != '0 && !start_i && !abort_i) |=> (st_q.cnt == $past(st_q.cnt) - CNT_W'(1))); // R5

endmodule

// File: rtl/cfg_descr_arith.sv
// Combinational parts of one key step: offset sum and multiply-accumulate.
module cfg_descr_arith #(
    parameter int               KEY_W  = 32,
    parameter int               RES_W  = 8,
    parameter logic [KEY_W-1:0] OFFSET = '0,
    parameter logic [KEY_W-1:0] FACTOR = '0
) (
    input  logic [KEY_W-1:0] key_i,
    input  logic [RES_W-1:0] rem_i,
    output logic [KEY_W-1:0] sum_o,
    output logic [KEY_W-1:0] next_key_o
);

    always_comb begin
        sum_o      = key_i + OFFSET;
        next_key_o = key_i * FACTOR + KEY_W'(rem_i);
    end

endmodule

// File: rtl/cfg_descrambler.sv
module cfg_descrambler
    import cfg_descr_pkg::*;
#(
    parameter int               KEY_W          = KEY_BITS,
    parameter int               BYTE_W         = 8,
    parameter int               BITS_PER_CYCLE = 2,
    parameter int               MODULUS        = KEY_MOD,
    parameter logic [KEY_W-1:0] SEED           = KEY_W'(KEY_SEED),
    parameter logic [KEY_W-1:0] OFFSET         = KEY_W'(KEY_OFFSET),
    parameter logic [KEY_W-1:0] FACTOR         = KEY_W'(KEY_FACTOR),
    localparam int RES_W = $clog2(MODULUS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              restart_i,
    input  logic              in_valid_i,
    output logic              in_ready_o,
    input  logic [BYTE_W-1:0] in_data_i,
    output logic              out_valid_o,
    input  logic              out_ready_i,
    output logic [BYTE_W-1:0] out_data_o
);

    typedef struct packed {
        phase_e            phase;
        logic [KEY_W-1:0]  key;
        logic [BYTE_W-1:0] held;
        logic [BYTE_W-1:0] dout;
    } top_st_t;

    top_st_t st_q, st_d;

    logic             accept;
    logic             rem_done;
    logic [RES_W-1:0] rem_val;
    logic [KEY_W-1:0] key_sum;
    logic [KEY_W-1:0] key_next;

    cfg_descr_arith #(
        .KEY_W  (KEY_W),
        .RES_W  (RES_W),
        .OFFSET (OFFSET),
        .FACTOR (FACTOR)
    ) u_arith (
        .key_i      (st_q.key),
        .rem_i      (rem_val),
        .sum_o      (key_sum),
        .next_key_o (key_next)
    );

    cfg_descr_rem #(
        .KEY_W          (KEY_W),
        .MODULUS        (MODULUS),
        .BITS_PER_CYCLE (BITS_PER_CYCLE)
    ) u_rem (
        .clk        (clk),
        .rst_n      (rst_n),
        .abort_i    (restart_i),
        .start_i    (accept),
        .dividend_i (key_sum),
        .done_o     (rem_done),
        .rem_o      (rem_val)
    );

    assign in_ready_o  = (st_q.phase == PH_IDLE);
    assign out_valid_o = (st_q.phase == PH_HOLD);
    assign out_data_o  = st_q.dout;
    assign accept      = in_valid_i && in_ready_o && !restart_i;

    always_comb begin
        st_d = st_q;
        if (restart_i) begin
            st_d.phase = PH_IDLE;
            st_d.key   = SEED;
        end else begin
            unique case (st_q.phase)
                PH_IDLE: begin
                    if (accept) begin
                        st_d.held  = in_data_i;
                        st_d.phase = PH_CALC;
                    end
                end
                PH_CALC: begin
                    if (rem_done) begin
                        st_d.key   = key_next;
                        st_d.dout  = st_q.held ^ key_next[BYTE_W-1:0];
                        st_d.phase = PH_HOLD;
                    end
                end
                PH_HOLD: begin
                    if (out_ready_i) begin
                        st_d.phase = PH_IDLE;
                    end
                end
                default: st_d.phase = PH_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q       <= '0;
            st_q.phase <= PH_IDLE;
            st_q.key   <= SEED;
        end else begin
            st_q <= st_d;
        end
    end

    AST_BUSY_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid_i && in_ready_o && !restart_i) |=> !in_ready_o); // R4

    AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!rst_n || restart_i)
        (out_valid_o && !out_ready_i) |=> (out_valid_o && $stable(out_data_o))); // R6

    AST_RESTART_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        restart_i |=> (in_ready_o && !out_valid_o)); // R7

    AST_KEY_ONLY_ON_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (!restart_i && !(st_q.phase == PH_CALC && rem_done)) |=> $stable(st_q.key)); // R3

endmodule

// File: tb/cfg_descrambler_tb.sv
`timescale 1ns/1ps
module cfg_descrambler_tb;

    localparam int          KEY_W = 32;
    localparam int          BPC   = 2;
    localparam int          STEPS = KEY_W / BPC;
    localparam int          VIS   = STEPS + 2;
    localparam logic [31:0] SEED  = 32'h3F6DF2AB;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       restart = 1'b0;
    logic       in_valid = 1'b0;
    logic       in_ready;
    logic [7:0] in_data = 8'h00;
    logic       out_valid;
    logic       out_ready = 1'b0;
    logic [7:0] out_data;

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    cfg_descrambler #(.BITS_PER_CYCLE(BPC)) u_dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .restart_i   (restart),
        .in_valid_i  (in_valid),
        .in_ready_o  (in_ready),
        .in_data_i   (in_data),
        .out_valid_o (out_valid),
        .out_ready_i (out_ready),
        .out_data_o  (out_data)
    );

    function automatic logic [31:0] step_key(input logic [31:0] k);
        logic [31:0] s;
        s = k + 32'h0A853753;
        return (s % 32'd177) + k * 32'h08034052;
    endfunction

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    // Reference model state
    logic [31:0] m_key = SEED;
    bit          m_busy = 1'b0;
    int          m_age = 0;
    bit          m_from_restart = 1'b0;
    logic [7:0]  q_data[$];
    string       q_tag[$];
    int          n_acc = 0, n_out = 0, n_drop = 0;
    bit          first_sample = 1'b1;
    bit          p_ov = 1'b0, p_or = 1'b0, p_rs = 1'b0, p_r8 = 1'b0;
    logic [7:0]  p_od = 8'h00;

    // Monitor: samples just before each rising edge and models that edge.
    always @(negedge clk) begin
        #2.0;
        if (rst_n && !finished) begin
            if (m_busy) m_age++;
            if (first_sample) begin
                chk(in_ready === 1'b1, "R1 in_ready after reset", in_ready, 1);
                chk(out_valid === 1'b0, "R1 out_valid after reset", out_valid, 0);
                first_sample = 1'b0;
            end
            chk(in_ready === !m_busy, p_r8 ? "R8 in_ready" : "R4 in_ready", in_ready, !m_busy);
            chk(out_valid === (m_busy && m_age >= VIS), "R5 out_valid timing", out_valid, (m_busy && m_age >= VIS));
            if (p_ov && !p_or && !p_rs)
                chk(out_valid === 1'b1 && out_data === p_od, "R6 hold under back-pressure", out_data, p_od);
            p_r8 = restart && in_valid && in_ready;
            if (restart) begin
                if (m_busy) n_drop++;
                m_busy = 1'b0;
                m_key = SEED;
                m_from_restart = 1'b1;
                q_data.delete();
                q_tag.delete();
            end else begin
                if (out_valid && out_ready) begin
                    n_out++;
                    if (q_data.size() == 0) begin
                        chk(1'b0, "R9 output without pending byte", out_data, 0);
                    end else begin
                        logic [7:0] e;
                        string t;
                        e = q_data.pop_front();
                        t = q_tag.pop_front();
                        chk(out_data === e, t, out_data, e);
                    end
                    m_busy = 1'b0;
                end
                if (in_valid && in_ready) begin
                    string t;
                    if (m_key == SEED) t = m_from_restart ? "R7 first byte after restart" : "R2 first byte after seed";
                    else t = "R3 chained byte";
                    m_key = step_key(m_key);
                    q_data.push_back(in_data ^ m_key[7:0]);
                    q_tag.push_back(t);
                    m_busy = 1'b1;
                    m_age = 0;
                    n_acc++;
                end
            end
            p_ov = out_valid;
            p_or = out_ready;
            p_rs = restart;
            p_od = out_data;
        end
    end

    task automatic tick();
        @(negedge clk);
        #0.5;
    endtask

    task automatic idle_cycles(input int n);
        for (int i = 0; i < n; i++) tick();
    endtask

    logic [31:0] lcg = 32'h1234_5678;
    function automatic logic [31:0] nxt(input logic [31:0] v);
        return v * 32'd1664525 + 32'd1013904223;
    endfunction

    task automatic finish_run();
        finished = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    initial begin
        #750000;
        chk(1'b0, "watchdog expired", 0, 1);
        finish_run();
    end

    initial begin
        idle_cycles(4);
        rst_n = 1'b1;
        idle_cycles(2);

        // Streaming with an always-ready consumer, counting data (R2, R3)
        out_ready = 1'b1;
        in_valid = 1'b1;
        for (int i = 0; i < 40; i++) begin
            in_data = 8'(i);
            do tick(); while (!(in_valid && in_ready) && 1'b0);
            idle_cycles(STEPS + 3);
        end
        in_data = 8'hFF;
        idle_cycles(60);
        in_data = 8'h00;
        idle_cycles(60);
        in_valid = 1'b0;
        idle_cycles(VIS + 4);

        // Restart during the remainder computation (R7)
        in_valid = 1'b1; in_data = 8'hA5;
        tick();
        in_valid = 1'b0;
        idle_cycles(5);
        restart = 1'b1; tick(); restart = 1'b0;
        in_valid = 1'b1; in_data = 8'h3C; tick(); in_valid = 1'b0;
        idle_cycles(VIS + 4);

        // Restart while a result is parked behind a stalled consumer (R6, R7)
        out_ready = 1'b0;
        in_valid = 1'b1; in_data = 8'h5A; tick(); in_valid = 1'b0;
        idle_cycles(VIS + 8);
        restart = 1'b1; tick(); restart = 1'b0;
        out_ready = 1'b1;
        in_valid = 1'b1; in_data = 8'hC3; tick(); in_valid = 1'b0;
        idle_cycles(VIS + 4);

        // Restart together with a valid byte while idle (R8)
        restart = 1'b1; in_valid = 1'b1; in_data = 8'h77; tick();
        restart = 1'b0; in_valid = 1'b0;
        idle_cycles(2);
        in_valid = 1'b1; in_data = 8'h11; tick(); in_valid = 1'b0;
        idle_cycles(VIS + 4);

        // Random traffic, back-pressure and sparse restarts (R3, R6, R9)
        for (int i = 0; i < 4000; i++) begin
            lcg = nxt(lcg);
            in_valid  = lcg[20];
            out_ready = lcg[21] | lcg[22];
            in_data   = lcg[31:24];
            restart   = (lcg[15:8] < 8'd2);
            tick();
        end
        restart = 1'b0; in_valid = 1'b0; out_ready = 1'b1;
        idle_cycles(VIS + 6);

        chk(n_out == n_acc - n_drop, "R9 output count", n_out, n_acc - n_drop);
        chk(q_data.size() == 0, "R9 nothing pending", q_data.size(), 0);
        finish_run();
    end

endmodule